// File: doc/BRIEF.md
# Serial Port Status and Interrupt Identification

This block holds the status side of a serial port: a line status register with sticky receive error flags, a modem status register with sticky change flags beside the current line levels, and an interrupt identification register that names the most urgent enabled source. The receive and transmit datapaths report events to it as single-cycle pulses. The modem control lines arrive asynchronously and are synchronised here. Software reads each register through a select code. A read returns the value combinationally. The clearing side effect takes place at the clock edge that ends the read cycle.

The clear is built as a mask of the bits the read returned. An event pulse that arrives in the same cycle as the read is ORed in after the mask is applied. A flag raised during a read is therefore kept and shows up on the next read, instead of being wiped along with the value that software saw.

Top module: `sio_status_unit`

## Requirements
- R1: The line status value is {3'b000, break, framing, parity, overrun, rx_has_data}, with bit 0 following `rx_has_data` directly. Reading select 0 with `rd_en` clears exactly the error bits 4:1 that the read returned.
- R2: An error pulse that arrives in the same cycle as a line status read is not reported by that read, stays set, and appears on the next read.
- R3: The modem status value is {dcd, ri, dsr, cts} levels in bits 7:4 and their change flags in bits 3:0 (cts bit 0, dsr bit 1, ri bit 2, dcd bit 3). Reading select 2 clears the returned change flags. A change detected in the cycle of the read is kept for the next read.
- R4: A change flag is set when the synchronised level of its line changes. For cts, dsr and dcd any change counts. For ri only a 1-to-0 transition counts. A change is visible in the status three clock edges after the input moves.
- R5: The identification value is {5'b0, code[1:0], none}. Codes are 3 for a line error, 2 for received data, 1 for transmit holding empty and 0 for a modem change, and this order is also the priority. With nothing pending and enabled the value is 8'h01.
- R6: `int_en` bits enable received data (0), transmit empty (1), line error (2) and modem change (3). A disabled source is never reported. `irq` is high exactly when some enabled source is pending.
- R7: A read of select 1 with `rd_en` clears the transmit-empty flag only when that read reports code 1. A `thre_set` pulse in the same cycle keeps the flag set.
- R8: A `thr_write` pulse clears the transmit-empty flag. A `thre_set` in the same cycle wins.
- R9: After reset the line status and modem status values read 0 (inputs low), the identification value reads 8'h01 and `irq` is low.
- R10: Select 3 reads as 0. No read clears any register other than the one selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_overrun | input | 1 | Receive overrun pulse |
| ev_parity | input | 1 | Parity error pulse |
| ev_frame | input | 1 | Framing error pulse |
| ev_break | input | 1 | Break detected pulse |
| rx_has_data | input | 1 | Received data available (level) |
| thre_set | input | 1 | Transmit holding register became empty (pulse) |
| thr_write | input | 1 | Transmit holding register written (pulse) |
| cts_in | input | 1 | Clear-to-send line, asynchronous |
| dsr_in | input | 1 | Data-set-ready line, asynchronous |
| ri_in | input | 1 | Ring indicator line, asynchronous |
| dcd_in | input | 1 | Carrier detect line, asynchronous |
| int_en | input | 4 | Interrupt source enables |
| rd_en | input | 1 | Read strobe, applies clearing side effects |
| rd_sel | input | 2 | Register select: 0 line, 1 identification, 2 modem, 3 none |
| rd_data | output | 8 | Read data for the selected register |
| irq | output | 1 | Interrupt request |

## Verification
The bench aims at reads that coincide with new events: error pulses during a line status read, a modem change that ripens in the read cycle, and a transmit-empty pulse during an identification read. A design that clears whole registers on read would drop these events silently. It sweeps all sixteen pending-source sets against all sixteen enable masks. A wrong priority chain or an ungated source would report the wrong code or raise `irq` spuriously. It also checks that the transmit-empty flag survives an identification read reporting a higher or lower source, and that ring only flags on its trailing edge. A design that cleared on any identification read, or flagged both ring edges, would fail these checks.

// File: rtl/sio_stat_pkg.sv
package sio_stat_pkg;

    localparam int REG_W  = 8;
    localparam int N_ERR  = 4;
    localparam int N_LINE = 4;
    localparam int RI_IDX = 2;

    typedef enum logic [1:0] {
        SEL_LINE  = 2'd0,
        SEL_IDENT = 2'd1,
        SEL_MODEM = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        SRC_MODEM   = 2'd0,
        SRC_TXEMPTY = 2'd1,
        SRC_RXDATA  = 2'd2,
        SRC_LINE    = 2'd3
    } int_src_e;

    typedef struct packed {
        logic brk;
        logic frame;
        logic parity;
        logic overrun;
    } line_err_t;

    typedef struct packed {
        logic modem;
        logic line;
        logic txempty;
        logic rxdata;
    } int_vec_t;

    function automatic logic [REG_W-1:0] pack_line(line_err_t e, logic rx);
        return {3'b000, e, rx};
    endfunction

    function automatic logic [REG_W-1:0] pack_modem(logic [N_LINE-1:0] lvl,
                                                    logic [N_LINE-1:0] dlt);
        return {lvl, dlt};
    endfunction

    function automatic logic [REG_W-1:0] pack_ident(logic none, int_src_e s);
        return {5'b00000, s, none};
    endfunction

endpackage

// File: rtl/sio_sticky.sv
module sio_sticky #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    // set has priority over clear so a same-cycle event is never lost
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clr) | set;
    end
endmodule

// File: rtl/sio_line_sync.sv
module sio_line_sync #(
    parameter int STAGES    = 2,
    parameter bit FALL_ONLY = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic lvl,
    output logic chg
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain;
    logic         prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[TOP-1:0], d};
            prev  <= chain[TOP];
        end
    end

    assign lvl = chain[TOP];

    generate
        if (FALL_ONLY) begin : g_fall
            assign chg = prev & ~lvl;
        end else begin : g_any
            assign chg = prev ^ lvl;
        end
    endgenerate
endmodule

// File: rtl/sio_int_prio.sv
module sio_int_prio
    import sio_stat_pkg::*;
(
    input  int_vec_t pend,
    input  int_vec_t en,
    output logic     none,
    output int_src_e src
);
    int_vec_t act;

    always_comb begin
        act  = pend & en;
        none = 1'b0;
        if (act.line)         src = SRC_LINE;
        else if (act.rxdata)  src = SRC_RXDATA;
        else if (act.txempty) src = SRC_TXEMPTY;
        else begin
            src  = SRC_MODEM;
            none = ~act.modem;
        end
    end
endmodule

// File: rtl/sio_status_unit.sv
module sio_status_unit
    import sio_stat_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_overrun,
    input  logic             ev_parity,
    input  logic             ev_frame,
    input  logic             ev_break,
    input  logic             rx_has_data,
    input  logic             thre_set,
    input  logic             thr_write,
    input  logic             cts_in,
    input  logic             dsr_in,
    input  logic             ri_in,
    input  logic             dcd_in,
    input  logic [3:0]       int_en,
    input  logic             rd_en,
    input  logic [1:0]       rd_sel,
    output logic [REG_W-1:0] rd_data,
    output logic             irq
);
    logic [N_ERR-1:0]  err_set_v, err_q_v, err_clr_v;
    logic [N_LINE-1:0] raw_v, lvl_v, chg_v, dlt_q, dlt_clr;
    logic              thre_q, thre_clr;
    logic              rd_line, rd_ident, rd_modem;
    logic              none;
    int_src_e          src;
    int_vec_t          pend;
    reg_sel_e          sel;

    assign sel      = reg_sel_e'(rd_sel);
    assign rd_line  = rd_en && (sel == SEL_LINE);
    assign rd_ident = rd_en && (sel == SEL_IDENT);
    assign rd_modem = rd_en && (sel == SEL_MODEM);

    // receive error flags
    assign err_set_v = {ev_break, ev_frame, ev_parity, ev_overrun};
    assign err_clr_v = rd_line ? err_q_v : '0;

    sio_sticky #(.W(N_ERR)) u_err (
        .clk (clk),
        .rst (rst),
        .set (err_set_v),
        .clr (err_clr_v),
        .q   (err_q_v)
    );

    // modem lines: synchronise and detect changes
    assign raw_v = {dcd_in, ri_in, dsr_in, cts_in};

    generate
        for (genvar gi = 0; gi < N_LINE; gi++) begin : g_line
            sio_line_sync #(
                .STAGES    (SYNC_STAGES),
                .FALL_ONLY (gi == RI_IDX)
            ) u_sync (
                .clk (clk),
                .rst (rst),
                .d   (raw_v[gi]),
                .lvl (lvl_v[gi]),
                .chg (chg_v[gi])
            );
        end
    endgenerate

    assign dlt_clr = rd_modem ? dlt_q : '0;

    sio_sticky #(.W(N_LINE)) u_dlt (
        .clk (clk),
        .rst (rst),
        .set (chg_v),
        .clr (dlt_clr),
        .q   (dlt_q)
    );

    // transmit holding empty flag
    assign thre_clr = thr_write | (rd_ident & ~none & (src == SRC_TXEMPTY));

    sio_sticky #(.W(1)) u_thre (
        .clk (clk),
        .rst (rst),
        .set (thre_set),
        .clr (thre_clr),
        .q   (thre_q)
    );

    // interrupt identification
    always_comb begin
        pend.line    = |err_q_v;
        pend.rxdata  = rx_has_data;
        pend.txempty = thre_q;
        pend.modem   = |dlt_q;
    end

    sio_int_prio u_prio (
        .pend (pend),
        .en   (int_vec_t'(int_en)),
        .none (none),
        .src  (src)
    );

    assign irq = ~none;

    // read mux, independent of rd_en so a select alone shows the value
    always_comb begin
        case (sel)
            SEL_LINE:  rd_data = pack_line(line_err_t'(err_q_v), rx_has_data);
            SEL_IDENT: rd_data = pack_ident(none, src);
            SEL_MODEM: rd_data = pack_modem(lvl_v, dlt_q);
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/sio_status_checks.sv
module sio_status_checks (
    input logic       clk,
    input logic       rst,
    input logic [3:0] err_set_v,
    input logic [3:0] err_q_v,
    input logic       rd_en,
    input logic [1:0] rd_sel,
    input logic [7:0] rd_data,
    input logic       irq,
    input logic [3:0] int_en,
    input logic       rx_has_data,
    input logic [3:0] dlt_q,
    input logic [3:0] chg_v,
    input logic       thre_q,
    input logic       thre_set,
    input logic       thr_write
);
    assert_err_kept_R2: assert property (@(posedge clk) disable iff (rst)
        (err_set_v != 4'b0) |=> ((err_q_v & $past(err_set_v)) == $past(err_set_v)));

    assert_line_clear_R1: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_sel == 2'd0 && err_set_v == 4'b0) |=> (err_q_v == 4'b0));

    assert_modem_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_sel == 2'd2 && chg_v == 4'b0) |=> (dlt_q == 4'b0));

    assert_thre_kept_R7: assert property (@(posedge clk) disable iff (rst)
        thre_set |=> thre_q);

    assert_thr_write_R8: assert property (@(posedge clk) disable iff (rst)
        (thr_write && !thre_set) |=> !thre_q);

    assert_rx_rank_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_sel == 2'd1 && rx_has_data && int_en[0] && !((err_q_v != 4'b0) && int_en[2]))
        |-> (rd_data == 8'h04));

    assert_irq_gated_R6: assert property (@(posedge clk) disable iff (rst)
        (int_en == 4'b0) |-> !irq);
endmodule

bind sio_status_unit sio_status_checks u_checks (
    .clk         (clk),
    .rst         (rst),
    .err_set_v   (err_set_v),
    .err_q_v     (err_q_v),
    .rd_en       (rd_en),
    .rd_sel      (rd_sel),
    .rd_data     (rd_data),
    .irq         (irq),
    .int_en      (int_en),
    .rx_has_data (rx_has_data),
    .dlt_q       (dlt_q),
    .chg_v       (chg_v),
    .thre_q      (thre_q),
    .thre_set    (thre_set),
    .thr_write   (thr_write)
);

// File: tb/sio_status_unit_bench.sv
module sio_status_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 4;

    logic       clk = 1'b0;
    logic       rst;
    logic       ev_overrun, ev_parity, ev_frame, ev_break;
    logic       rx_has_data, thre_set, thr_write;
    logic [3:0] mline;
    logic [3:0] int_en;
    logic       rd_en;
    logic [1:0] rd_sel;
    logic [7:0] rd_data;
    logic       irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sio_status_unit u_sio_status_unit (
        .clk         (clk),
        .rst         (rst),
        .ev_overrun  (ev_overrun),
        .ev_parity   (ev_parity),
        .ev_frame    (ev_frame),
        .ev_break    (ev_break),
        .rx_has_data (rx_has_data),
        .thre_set    (thre_set),
        .thr_write   (thr_write),
        .cts_in      (mline[0]),
        .dsr_in      (mline[1]),
        .ri_in       (mline[2]),
        .dcd_in      (mline[3]),
        .int_en      (int_en),
        .rd_en       (rd_en),
        .rd_sel      (rd_sel),
        .rd_data     (rd_data),
        .irq         (irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        {ev_break, ev_frame, ev_parity, ev_overrun} = 4'b0;
        thre_set  = 1'b0;
        thr_write = 1'b0;
        rd_en     = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] v);
        rd_en  = 1'b1;
        rd_sel = sel;
        #1;
        v = rd_data;
        step();
    endtask

    task automatic peek(input logic [1:0] sel, output logic [7:0] v);
        rd_en  = 1'b0;
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    function automatic logic [7:0] exp_ident(input logic [3:0] act);
        if (act[2])      return 8'h06;
        else if (act[0]) return 8'h04;
        else if (act[1]) return 8'h02;
        else if (act[3]) return 8'h00;
        else             return 8'h01;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        rst = 1'b1;
        {ev_break, ev_frame, ev_parity, ev_overrun} = 4'b0;
        rx_has_data = 1'b0;
        thre_set = 1'b0;
        thr_write = 1'b0;
        mline = 4'b0;
        int_en = 4'b0;
        rd_en = 1'b0;
        rd_sel = 2'd0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R9 reset state
        peek(2'd0, v); check("R9 line", v, 8'h00);
        peek(2'd2, v); check("R9 modem", v, 8'h00);
        int_en = 4'hF;
        peek(2'd1, v); check("R9 ident", v, 8'h01);
        check("R9 irq", {7'b0, irq}, 8'h00);
        int_en = 4'h0;
        step();

        // R1 sweep over every error combination and rx level
        for (int m = 0; m < 16; m++) begin
            rx_has_data = m[0];
            {ev_break, ev_frame, ev_parity, ev_overrun} = 4'(m);
            step();
            rd(2'd0, v); check("R1 read", v, 8'((m << 1) | (m & 1)));
            rd(2'd0, v); check("R1 cleared", v, 8'(m & 1));
        end
        rx_has_data = 1'b0;

        // R2 error pulse coinciding with the read
        for (int m = 1; m < 16; m++) begin
            {ev_break, ev_frame, ev_parity, ev_overrun} = 4'(m);
            rd(2'd0, v); check("R2 same-cycle read", v, 8'h00);
            rd(2'd0, v); check("R2 next read", v, 8'(m << 1));
        end

        // R4 change detection per line, both directions
        for (int i = 0; i < 4; i++) begin
            mline[i] = 1'b1;
            repeat (SETTLE) step();
            rd(2'd2, v);
            check("R4 rise", v, 8'((1 << (i + 4)) | ((i == 2) ? 0 : (1 << i))));
            rd(2'd2, v); check("R3 rise cleared", v, 8'(1 << (i + 4)));
            mline[i] = 1'b0;
            repeat (SETTLE) step();
            rd(2'd2, v); check("R4 fall", v, 8'(1 << i));
            rd(2'd2, v); check("R3 fall cleared", v, 8'h00);
        end

        // R4 latency: a change is not visible after two edges
        mline[1] = 1'b1;
        step(); step();
        peek(2'd2, v); check("R4 two edges", v, 8'h20);
        step();
        peek(2'd2, v); check("R4 three edges", v, 8'h22);
        rd(2'd2, v);
        mline[1] = 1'b0;
        repeat (SETTLE) step();
        rd(2'd2, v);

        // R3 change ripening in the cycle of the read
        mline[0] = 1'b1;
        step(); step();
        rd(2'd2, v); check("R3 same-cycle read", v, 8'h10);
        rd(2'd2, v); check("R3 next read", v, 8'h11);
        mline[0] = 1'b0;
        repeat (SETTLE) step();
        rd(2'd2, v); check("R3 restore", v, 8'h01);

        // R5 R6 sweep of pending sets against enable masks
        for (int p = 0; p < 16; p++) begin
            rx_has_data = p[0];
            thre_set    = p[1];
            ev_parity   = p[2];
            if (p[3]) mline[3] = ~mline[3];
            step();
            repeat (SETTLE) step();
            for (int e = 0; e < 16; e++) begin
                int_en = 4'(e);
                peek(2'd1, v);
                check("R5 ident", v, exp_ident(4'(p & e)));
                check("R6 irq", {7'b0, irq}, {7'b0, ((p & e) != 0)});
            end
            int_en = 4'h0;
            rd(2'd0, v);
            rd(2'd2, v);
            thr_write = 1'b1;
            step();
            rx_has_data = 1'b0;
        end
        peek(2'd2, v); check("R3 sweep settled", v, 8'h00);

        // R7 transmit-empty clear by identification read
        int_en = 4'hF;
        thre_set = 1'b1; step();
        rd(2'd1, v); check("R7 reports tx empty", v, 8'h02);
        peek(2'd1, v); check("R7 cleared by read", v, 8'h01);

        thre_set = 1'b1; rx_has_data = 1'b1; step();
        rd(2'd1, v); check("R7 rx outranks", v, 8'h04);
        rx_has_data = 1'b0;
        peek(2'd1, v); check("R7 kept under rx", v, 8'h02);

        // R8 holding register write
        thr_write = 1'b1; step();
        peek(2'd1, v); check("R8 write clears", v, 8'h01);
        thre_set = 1'b1; thr_write = 1'b1; step();
        peek(2'd1, v); check("R8 set wins", v, 8'h02);

        // R7 set pulse coinciding with the clearing read
        thre_set = 1'b1;
        rd(2'd1, v); check("R7 same-cycle read", v, 8'h02);
        peek(2'd1, v); check("R7 same-cycle kept", v, 8'h02);
        thr_write = 1'b1; step();

        // R7 read reporting modem change while set pulse arrives
        mline[3] = ~mline[3];
        repeat (SETTLE) step();
        thre_set = 1'b1;
        rd(2'd1, v); check("R7 modem reported", v, 8'h00);
        peek(2'd1, v); check("R7 kept after modem read", v, 8'h02);
        thr_write = 1'b1; step();
        rd(2'd2, v);
        mline[3] = 1'b0;
        repeat (SETTLE) step();
        rd(2'd2, v);

        // R10 reads of one register leave the others alone
        int_en = 4'h0;
        ev_parity = 1'b1; step();
        rd(2'd3, v); check("R10 empty select", v, 8'h00);
        rd(2'd1, v); check("R10 ident idle", v, 8'h01);
        rd(2'd2, v); check("R10 modem", v, 8'h00);
        rd(2'd0, v); check("R10 line kept", v, 8'h04);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule